// File: doc/BRIEF.md
# Clear-on-Read Ethernet Port Statistics Counters

This block keeps one bank of management statistics counters per Ethernet port. Each port's receive and transmit MACs report every finished frame as a one-cycle event strobe carrying the frame length in bytes and a set of status flags. The block sorts each event into the matching counters: traffic-type counts, error counts, collision and deferral counts, byte totals, and a histogram of frame lengths across seven fixed bins. Counters are `CNT_W` bits wide and wrap modulo 2^CNT_W.

The host reads the counters over a simple word-addressed read port. The address holds the port number in its upper bits and the counter's word index in its lower six bits. A read returns the counter one cycle later and zeroes it at the same time. The host therefore sees the events that arrived since its previous read and never has to clear anything itself. When a frame event hits the counter being read in the same cycle, the read returns the old total and the counter restarts from that frame's contribution, so no event is lost.

Top module: `port_mib_counters`

## Requirements
- R1: After synchronous active-low reset, every counter reads as 0 and `rd_valid` is low.
- R2: A read issued with `rd_en` high and `rd_addr = {port, word}` (word in the low 6 bits) gives `rd_valid` high one cycle later, with `rd_data` equal to the counter's value in the issuing cycle. Without `rd_en`, `rd_valid` and `rd_data` are 0. Word map: receive good bytes 0, bad bytes 1, broadcast 2, multicast 3, pause 4, FCS error 5, alignment error 6, runt 7, fragment 8, too long 9, overflow 10, filtered 11, length bins 12..18. Transmit bytes 19, broadcast 20, multicast 21, pause 22, underrun 23, oversize 24, collisions 25, single collision 26, multiple collision 27, abort collision 28, excessive deferral 29, deferral 30, late collision 31, length bins 32..38.
- R3: Reading a counter sets it to zero, so a second read with no new events in between returns 0.
- R4: Length bins: bin 0 holds exactly 64 bytes, bin 1 holds 65-127, bin 2 holds 128-255, bin 3 holds 256-511, bin 4 holds 512-1023, bin 5 holds 1024-1518, bin 6 holds 1519 up to MAX_LEN (default 1536). A receive frame is good when FCS error, alignment error and overflow are all clear and its length lies between 64 and MAX_LEN. Only good frames increment a receive bin.
- R5: `rx_flags` bits are: 0 broadcast, 1 multicast, 2 pause, 3 FCS error, 4 alignment error, 5 overflow, 6 filtered. Each set flag increments its own counter on every receive frame. A frame under 64 bytes counts as a runt when bits 3 and 4 are both clear, and as a fragment otherwise. A frame over MAX_LEN counts as too long.
- R6: A good receive frame adds its length to good bytes. Any other receive frame adds its length to bad bytes.
- R7: `tx_flags` bits are: 0 broadcast, 1 multicast, 2 pause, 3 underrun, 4 abort collision, 5 excessive deferral, 6 deferral, 7 late collision. Each set flag increments its own counter. A transmit frame is completed when bits 3, 4 and 7 are all clear. A completed frame adds its length to transmit bytes, and also increments a length bin when its length is 64..MAX_LEN. Any transmit frame over MAX_LEN increments oversize.
- R8: The collisions counter adds `tx_col_cnt`. When abort collision is clear, a `tx_col_cnt` of exactly 1 increments single collision and a `tx_col_cnt` of 2 or more increments multiple collision.
- R9: When a read and a frame event hit the same counter in one cycle, the read returns the pre-event value and the counter then holds exactly that event's increment.
- R10: Counters, byte counters included, wrap modulo 2^CNT_W.
- R11: Reading word 39..63, or any port number of NPORTS or above, returns 0 and changes no counter.
- R12: Events and reads on one port leave every other port's counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_ev | input | NPORTS | Receive frame event strobe, one bit per port |
| rx_len | input | NPORTS x LEN_W | Receive frame length in bytes |
| rx_flags | input | NPORTS x 7 | Receive status flags (R5) |
| tx_ev | input | NPORTS | Transmit frame event strobe, one bit per port |
| tx_len | input | NPORTS x LEN_W | Transmit frame length in bytes |
| tx_flags | input | NPORTS x 8 | Transmit status flags (R7) |
| tx_col_cnt | input | NPORTS x COL_W | Collisions seen while sending this frame |
| rd_en | input | 1 | Read request |
| rd_addr | input | PORT_W+6 | Port number (upper bits) and counter word (low 6 bits) |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | CNT_W | Counter value returned by the read |

## Verification
The two functions that can fall in the same cycle are the host's clear-on-read and a frame event that increments the counter being read. The bench provokes this by raising `rd_en` for a broadcast counter, and later for the good-byte counter, on the same clock edge as a receive event that bumps that counter. The returned value must equal the total accumulated before the event. A follow-up read must then return exactly the single event's contribution: one for the count, the frame length for the bytes. Length sweeps that straddle every bin edge, run against an arithmetic model, also check that a clear never drops or doubles increments on the neighbouring counters.

// File: rtl/mib_pkg.sv
// Package: shared counter word map, flag bit positions and length bins.
// Assumes frame lengths arrive in bytes; the bin edges are fixed constants.
package mib_pkg;

    // Receive flag bit positions
    localparam int RXF_BCAST = 0;
    localparam int RXF_MCAST = 1;
    localparam int RXF_PAUSE = 2;
    localparam int RXF_FCS   = 3;
    localparam int RXF_ALIGN = 4;
    localparam int RXF_OVF   = 5;
    localparam int RXF_FILT  = 6;
    localparam int RXF_N     = 7;

    // Transmit flag bit positions
    localparam int TXF_BCAST = 0;
    localparam int TXF_MCAST = 1;
    localparam int TXF_PAUSE = 2;
    localparam int TXF_UNDER = 3;
    localparam int TXF_ABORT = 4;
    localparam int TXF_EXDEF = 5;
    localparam int TXF_DEFER = 6;
    localparam int TXF_LATE  = 7;
    localparam int TXF_N     = 8;

    // Number of length-histogram bins
    localparam int BKT_N = 7;

    // Receive counter slots (global word = slot)
    localparam int RX_GOODB  = 0;
    localparam int RX_BADB   = 1;
    localparam int RX_BCAST  = 2;
    localparam int RX_MCAST  = 3;
    localparam int RX_PAUSE  = 4;
    localparam int RX_FCS    = 5;
    localparam int RX_ALIGN  = 6;
    localparam int RX_RUNT   = 7;
    localparam int RX_FRAG   = 8;
    localparam int RX_LONG   = 9;
    localparam int RX_OVF    = 10;
    localparam int RX_FILT   = 11;
    localparam int RX_BKT0   = 12;
    localparam int RX_N      = RX_BKT0 + BKT_N;

    // Transmit counter slots (global word = RX_N + slot)
    localparam int TX_BYTES  = 0;
    localparam int TX_BCAST  = 1;
    localparam int TX_MCAST  = 2;
    localparam int TX_PAUSE  = 3;
    localparam int TX_UNDER  = 4;
    localparam int TX_OVERSZ = 5;
    localparam int TX_COLL   = 6;
    localparam int TX_SINGLE = 7;
    localparam int TX_MULTI  = 8;
    localparam int TX_ABORT  = 9;
    localparam int TX_EXDEF  = 10;
    localparam int TX_DEFER  = 11;
    localparam int TX_LATE   = 12;
    localparam int TX_BKT0   = 13;
    localparam int TX_N      = TX_BKT0 + BKT_N;

    // Counters per port bank
    localparam int NCNT = RX_N + TX_N;

    // Smallest legal frame; also the only length of bin 0
    localparam int MIN_FRAME = 64;

    // Map an in-range frame length to its bin number (0..BKT_N-1)
    function automatic int len_bucket(input logic [31:0] len);
        if (len <= 32'd64)        return 0;
        else if (len <= 32'd127)  return 1;
        else if (len <= 32'd255)  return 2;
        else if (len <= 32'd511)  return 3;
        else if (len <= 32'd1023) return 4;
        else if (len <= 32'd1518) return 5;
        else                      return 6;
    endfunction

endpackage

// File: rtl/mib_rx_decode.sv
// Receive event decoder: turns one receive frame event into an increment
// amount per receive counter slot. Purely combinational.
// Assumes at most one receive event per port per cycle.
module mib_rx_decode
    import mib_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MAX_LEN = 1536
) (
    input  logic                          ev,
    input  logic [LEN_W-1:0]              len,
    input  logic [RXF_N-1:0]              flags,
    output logic [RX_N-1:0][LEN_W-1:0]    inc
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

    logic short_f;
    logic long_f;
    logic bad_f;
    logic good_f;

    // Classify the frame and set each slot's increment amount
    always_comb begin
        inc     = '0;
        short_f = len < MIN_L;
        long_f  = len > MAX_L;
        bad_f   = flags[RXF_FCS] | flags[RXF_ALIGN] | flags[RXF_OVF];
        good_f  = !bad_f && !short_f && !long_f;
        if (ev) begin
            if (good_f) inc[RX_GOODB] = len;
            else        inc[RX_BADB]  = len;
            inc[RX_BCAST] = LEN_W'(flags[RXF_BCAST]);
            inc[RX_MCAST] = LEN_W'(flags[RXF_MCAST]);
            inc[RX_PAUSE] = LEN_W'(flags[RXF_PAUSE]);
            inc[RX_FCS]   = LEN_W'(flags[RXF_FCS]);
            inc[RX_ALIGN] = LEN_W'(flags[RXF_ALIGN]);
            inc[RX_OVF]   = LEN_W'(flags[RXF_OVF]);
            inc[RX_FILT]  = LEN_W'(flags[RXF_FILT]);
            inc[RX_LONG]  = LEN_W'(long_f);
            if (short_f) begin
                if (flags[RXF_FCS] || flags[RXF_ALIGN]) inc[RX_FRAG] = ONE;
                else                                    inc[RX_RUNT] = ONE;
            end
            if (good_f) inc[RX_BKT0 + len_bucket(32'(len))] = ONE;
        end
    end

endmodule

// File: rtl/mib_tx_decode.sv
// Transmit event decoder: turns one transmit frame event into an increment
// amount per transmit counter slot. Purely combinational.
// Assumes LEN_W >= COL_W so a collision count fits an increment.
module mib_tx_decode
    import mib_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int COL_W   = 4,
    parameter int MAX_LEN = 1536
) (
    input  logic                          ev,
    input  logic [LEN_W-1:0]              len,
    input  logic [TXF_N-1:0]              flags,
    input  logic [COL_W-1:0]              col_cnt,
    output logic [TX_N-1:0][LEN_W-1:0]    inc
);

    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [COL_W-1:0] C1    = COL_W'(1);

    logic done_f;
    logic long_f;
    logic inrange_f;

    // Classify the frame and set each slot's increment amount
    always_comb begin
        inc       = '0;
        long_f    = len > MAX_L;
        inrange_f = (len >= MIN_L) && !long_f;
        done_f    = !flags[TXF_UNDER] && !flags[TXF_ABORT] && !flags[TXF_LATE];
        if (ev) begin
            if (done_f) inc[TX_BYTES] = len;
            inc[TX_BCAST]  = LEN_W'(flags[TXF_BCAST]);
            inc[TX_MCAST]  = LEN_W'(flags[TXF_MCAST]);
            inc[TX_PAUSE]  = LEN_W'(flags[TXF_PAUSE]);
            inc[TX_UNDER]  = LEN_W'(flags[TXF_UNDER]);
            inc[TX_ABORT]  = LEN_W'(flags[TXF_ABORT]);
            inc[TX_EXDEF]  = LEN_W'(flags[TXF_EXDEF]);
            inc[TX_DEFER]  = LEN_W'(flags[TXF_DEFER]);
            inc[TX_LATE]   = LEN_W'(flags[TXF_LATE]);
            inc[TX_OVERSZ] = LEN_W'(long_f);
            inc[TX_COLL]   = LEN_W'(col_cnt);
            if (!flags[TXF_ABORT]) begin
                if (col_cnt == C1)     inc[TX_SINGLE] = ONE;
                else if (col_cnt > C1) inc[TX_MULTI]  = ONE;
            end
            if (done_f && inrange_f) inc[TX_BKT0 + len_bucket(32'(len))] = ONE;
        end
    end

endmodule

// File: rtl/mib_bank.sv
// Counter bank for one port: NCNT wrapping counters, each with its own
// increment. A clear request for one word zeroes that counter before the
// same cycle's increment is added, so a coinciding event survives the clear.
// Assumes CNT_W >= INC_W.
module mib_bank #(
    parameter int NCNT   = 39,
    parameter int CNT_W  = 32,
    parameter int INC_W  = 14,
    parameter int WORD_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NCNT-1:0][INC_W-1:0]      inc,
    input  logic                            clr_en,
    input  logic [WORD_W-1:0]               clr_word,
    output logic [NCNT-1:0][CNT_W-1:0]      cnt
);

    logic [CNT_W-1:0] cnt_q [NCNT];

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        logic hit;
        assign hit = clr_en && (clr_word == WORD_W'(i));

        // Restart on clear-on-read, then add this cycle's increment (wraps)
        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[i] <= '0;
            else        cnt_q[i] <= (hit ? '0 : cnt_q[i]) + CNT_W'(inc[i]);
        end

        // Present the counter on the packed bank output
        always_comb cnt[i] = cnt_q[i];
    end

endmodule

// File: rtl/port_mib_counters.sv
// Top: per-port statistics counter banks with a clear-on-read host port.
// rd_addr = {port, word}; data returns one cycle after rd_en and the read
// counter is zeroed on the same edge. Unused words and absent ports read 0.
// Assumes BANK_WORDS is a power of two and at least NCNT.
module port_mib_counters
    import mib_pkg::*;
#(
    parameter int NPORTS     = 6,
    parameter int CNT_W      = 32,
    parameter int LEN_W      = 14,
    parameter int COL_W      = 4,
    parameter int MAX_LEN    = 1536,
    parameter int BANK_WORDS = 64,
    localparam int WORD_W    = $clog2(BANK_WORDS),
    localparam int PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int ADDR_W    = PORT_W + WORD_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NPORTS-1:0]                  rx_ev,
    input  logic [NPORTS-1:0][LEN_W-1:0]       rx_len,
    input  logic [NPORTS-1:0][RXF_N-1:0]       rx_flags,
    input  logic [NPORTS-1:0]                  tx_ev,
    input  logic [NPORTS-1:0][LEN_W-1:0]       tx_len,
    input  logic [NPORTS-1:0][TXF_N-1:0]       tx_flags,
    input  logic [NPORTS-1:0][COL_W-1:0]       tx_col_cnt,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic                               rd_valid,
    output logic [CNT_W-1:0]                   rd_data
);

    logic [PORT_W-1:0] rd_port;
    logic [WORD_W-1:0] rd_word;
    logic [NPORTS-1:0][NCNT-1:0][CNT_W-1:0] cnt_all;
    logic [CNT_W-1:0] rd_sel;

    assign rd_port = rd_addr[ADDR_W-1:WORD_W];
    assign rd_word = rd_addr[WORD_W-1:0];

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [RX_N-1:0][LEN_W-1:0] rx_inc;
        logic [TX_N-1:0][LEN_W-1:0] tx_inc;
        logic [NCNT-1:0][LEN_W-1:0] bank_inc;
        logic                       clr_en;

        mib_rx_decode #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_rx (
            .ev    (rx_ev[p]),
            .len   (rx_len[p]),
            .flags (rx_flags[p]),
            .inc   (rx_inc)
        );

        mib_tx_decode #(.LEN_W(LEN_W), .COL_W(COL_W), .MAX_LEN(MAX_LEN)) u_tx (
            .ev      (tx_ev[p]),
            .len     (tx_len[p]),
            .flags   (tx_flags[p]),
            .col_cnt (tx_col_cnt[p]),
            .inc     (tx_inc)
        );

        assign bank_inc = {tx_inc, rx_inc};
        assign clr_en   = rd_en && (rd_port == PORT_W'(p));

        mib_bank #(.NCNT(NCNT), .CNT_W(CNT_W), .INC_W(LEN_W), .WORD_W(WORD_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (bank_inc),
            .clr_en   (clr_en),
            .clr_word (rd_word),
            .cnt      (cnt_all[p])
        );
    end

    // Select the addressed counter; unmatched addresses yield zero
    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NPORTS; p++) begin
            for (int w = 0; w < NCNT; w++) begin
                if (rd_port == PORT_W'(p) && rd_word == WORD_W'(w)) rd_sel = cnt_all[p][w];
            end
        end
    end

    // Register the read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_sel : '0;
        end
    end

endmodule

// File: rtl/port_mib_counters_chk.sv
// Checker: read timing, clear-on-read, coincidence and port isolation
// properties for port_mib_counters. Attached by the bind at the end.
module port_mib_counters_chk
    import mib_pkg::*;
#(
    parameter int NPORTS = 6,
    parameter int CNT_W  = 32,
    parameter int WORD_W = 6,
    parameter int PORT_W = 3
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [NPORTS-1:0]                  rx_ev,
    input logic [NPORTS-1:0]                  tx_ev,
    input logic                               rd_en,
    input logic [PORT_W+WORD_W-1:0]           rd_addr,
    input logic                               rd_valid,
    input logic [CNT_W-1:0]                   rd_data,
    input logic [NPORTS-1:0][NCNT-1:0][CNT_W-1:0] cnt_all
);

    logic [PORT_W-1:0] c_port;
    logic [WORD_W-1:0] c_word;
    logic              c_ok;
    logic              c_quiet;

    assign c_port  = rd_addr[PORT_W+WORD_W-1:WORD_W];
    assign c_word  = rd_addr[WORD_W-1:0];
    assign c_ok    = (32'(c_port) < NPORTS) && (32'(c_word) < NCNT);
    assign c_quiet = c_ok && !rx_ev[c_port] && !tx_ev[c_port];

    // R2
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0));

    // R11
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !c_ok) |=> rd_data == '0);

    // R9
    old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && c_ok) |=> rd_data == $past(cnt_all[c_port][c_word]));

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && c_quiet) |=> cnt_all[$past(c_port)][$past(c_word)] == '0);

    for (genvar p = 0; p < NPORTS; p++) begin : g_iso
        // R12
        port_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_ev[p] && !tx_ev[p] && !(rd_en && c_port == PORT_W'(p))) |=> $stable(cnt_all[p]));
    end

endmodule

bind port_mib_counters port_mib_counters_chk #(
    .NPORTS (NPORTS),
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W),
    .PORT_W (PORT_W)
) chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_ev    (rx_ev),
    .tx_ev    (tx_ev),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .cnt_all  (cnt_all)
);

// File: tb/port_mib_counters_test.sv
`timescale 1ns/1ps
module port_mib_counters_test;

    localparam int NP    = 3;
    localparam int CW    = 16;
    localparam int LW    = 14;
    localparam int MAXL  = 1536;
    localparam int NUSED = 39;
    localparam int MASK  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]         rx_ev = '0;
    logic [NP-1:0][LW-1:0] rx_len = '0;
    logic [NP-1:0][6:0]    rx_flags = '0;
    logic [NP-1:0]         tx_ev = '0;
    logic [NP-1:0][LW-1:0] tx_len = '0;
    logic [NP-1:0][7:0]    tx_flags = '0;
    logic [NP-1:0][3:0]    tx_col = '0;
    logic                  rd_en = 1'b0;
    logic [7:0]            rd_addr = '0;
    logic                  rd_valid;
    logic [CW-1:0]         rd_data;

    int checks = 0;
    int fails = 0;
    int unsigned exp_q [4][64];

    always #4 clk = ~clk;

    port_mib_counters #(.NPORTS(NP), .CNT_W(CW), .LEN_W(LW), .MAX_LEN(MAXL)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_ev(rx_ev), .rx_len(rx_len), .rx_flags(rx_flags),
        .tx_ev(tx_ev), .tx_len(tx_len), .tx_flags(tx_flags), .tx_col_cnt(tx_col),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1200000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    task automatic check(input string tag, input string what, input int unsigned got, input int unsigned expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    function automatic int bin_of(input int len);
        if (len <= 64) return 0;
        if (len <= 127) return 1;
        if (len <= 255) return 2;
        if (len <= 511) return 3;
        if (len <= 1023) return 4;
        if (len <= 1518) return 5;
        return 6;
    endfunction

    function automatic void bump(input int p, input int w, input int amt);
        exp_q[p][w] = (exp_q[p][w] + amt) & MASK;
    endfunction

    // Receive model per R4, R5, R6
    function automatic void model_rx(input int p, input int len, input int fl);
        bit sh, lg, good;
        sh = len < 64;
        lg = len > MAXL;
        good = !fl[3] && !fl[4] && !fl[5] && !sh && !lg;
        bump(p, good ? 0 : 1, len);
        if (fl[0]) bump(p, 2, 1);
        if (fl[1]) bump(p, 3, 1);
        if (fl[2]) bump(p, 4, 1);
        if (fl[3]) bump(p, 5, 1);
        if (fl[4]) bump(p, 6, 1);
        if (sh && !fl[3] && !fl[4]) bump(p, 7, 1);
        if (sh && (fl[3] || fl[4])) bump(p, 8, 1);
        if (lg) bump(p, 9, 1);
        if (fl[5]) bump(p, 10, 1);
        if (fl[6]) bump(p, 11, 1);
        if (good) bump(p, 12 + bin_of(len), 1);
    endfunction

    // Transmit model per R7, R8
    function automatic void model_tx(input int p, input int len, input int fl, input int col);
        bit done;
        done = !fl[3] && !fl[4] && !fl[7];
        if (done) bump(p, 19, len);
        if (fl[0]) bump(p, 20, 1);
        if (fl[1]) bump(p, 21, 1);
        if (fl[2]) bump(p, 22, 1);
        if (fl[3]) bump(p, 23, 1);
        if (len > MAXL) bump(p, 24, 1);
        bump(p, 25, col);
        if (!fl[4] && col == 1) bump(p, 26, 1);
        if (!fl[4] && col > 1) bump(p, 27, 1);
        if (fl[4]) bump(p, 28, 1);
        if (fl[5]) bump(p, 29, 1);
        if (fl[6]) bump(p, 30, 1);
        if (fl[7]) bump(p, 31, 1);
        if (done && len >= 64 && len <= MAXL) bump(p, 32 + bin_of(len), 1);
    endfunction

    task automatic rx_frame(input int p, input int len, input int fl);
        @(negedge clk);
        rx_ev[p] = 1'b1; rx_len[p] = LW'(len); rx_flags[p] = 7'(fl);
        @(negedge clk);
        rx_ev[p] = 1'b0;
        model_rx(p, len, fl);
    endtask

    task automatic tx_frame(input int p, input int len, input int fl, input int col);
        @(negedge clk);
        tx_ev[p] = 1'b1; tx_len[p] = LW'(len); tx_flags[p] = 8'(fl); tx_col[p] = 4'(col);
        @(negedge clk);
        tx_ev[p] = 1'b0;
        model_tx(p, len, fl, col);
    endtask

    task automatic do_read(input int p, input int w, output int unsigned v, output logic vld);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'((p << 6) | w);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
        vld = rd_valid;
    endtask

    // Read every word of every port (unused words first), expect model, clear model
    task automatic dump(input string tag);
        int unsigned v;
        logic vld;
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 64; k++) begin
                int w;
                w = (k + NUSED) % 64;
                do_read(p, w, v, vld);
                if (p >= NP || w >= NUSED)
                    check("R11", $sformatf("port %0d word %0d", p, w), v, 0);
                else
                    check(tag, $sformatf("port %0d word %0d", p, w), v, exp_q[p][w]);
                exp_q[p][w] = 0;
            end
        end
    endtask

    initial begin
        int unsigned v;
        logic vld;
        int lens [19] = '{1, 40, 63, 64, 65, 100, 127, 128, 255, 256, 511, 512,
                          1023, 1024, 1518, 1519, 1536, 1537, 3000};
        int rxp [10] = '{0, 1, 2, 4, 8, 16, 32, 64, 24, 33};
        int txp [9]  = '{0, 1, 2, 4, 8, 16, 32, 64, 128};

        for (int p = 0; p < 4; p++)
            for (int w = 0; w < 64; w++) exp_q[p][w] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "rd_valid after reset", rd_valid, 0);
        dump("R1");

        // R2: read latency and valid flag
        do_read(0, 2, v, vld);
        check("R2", "rd_valid one cycle after rd_en", vld, 1);
        @(negedge clk);
        check("R2", "rd_valid without rd_en", rd_valid, 0);

        // R4, R5, R6: receive sweep on port 0 across bin edges and flag patterns
        foreach (lens[i]) foreach (rxp[j]) rx_frame(0, lens[i], rxp[j]);
        dump("R4");
        dump("R3");

        // R5: receive sweep on port 2 with combined error flags
        foreach (lens[i]) begin
            rx_frame(2, lens[i], 8);
            rx_frame(2, lens[i], 16 | 1);
            rx_frame(2, lens[i], 64 | 2);
        end
        dump("R5");

        // R7, R8: transmit sweep on port 1
        foreach (lens[i]) foreach (txp[j]) tx_frame(1, lens[i], txp[j], (i + j) % 4);
        tx_frame(1, 100, 16, 1);
        tx_frame(1, 100, 16, 3);
        dump("R7");
        dump("R3");

        // R12: events on port 1 only, port 0 and 2 must stay zero
        rx_frame(1, 300, 1);
        tx_frame(1, 70, 0, 2);
        dump("R12");

        // R9: read coinciding with an event on the read counter
        rx_frame(0, 100, 1);
        rx_frame(0, 100, 1);
        rx_frame(0, 100, 1);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'(2);
        rx_ev[0] = 1'b1; rx_len[0] = LW'(100); rx_flags[0] = 7'(1);
        @(negedge clk);
        rd_en = 1'b0; rx_ev[0] = 1'b0;
        check("R9", "broadcast read during event", rd_data, 3);
        exp_q[0][2] = 0;
        model_rx(0, 100, 1);
        do_read(0, 2, v, vld);
        check("R9", "broadcast after coincident clear", v, 1);
        exp_q[0][2] = 0;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'(0);
        rx_ev[0] = 1'b1; rx_len[0] = LW'(200); rx_flags[0] = 7'(0);
        @(negedge clk);
        rd_en = 1'b0; rx_ev[0] = 1'b0;
        check("R9", "good bytes read during event", rd_data, 400);
        exp_q[0][0] = 0;
        model_rx(0, 200, 0);
        do_read(0, 0, v, vld);
        check("R9", "good bytes after coincident clear", v, 200);
        exp_q[0][0] = 0;

        // R11: unused reads leave live counters intact
        rx_frame(0, 64, 2);
        do_read(0, 50, v, vld);
        check("R11", "unused word", v, 0);
        do_read(3, 3, v, vld);
        check("R11", "absent port", v, 0);
        do_read(0, 3, v, vld);
        check("R11", "multicast kept after unused reads", v, 1);
        exp_q[0][3] = 0;
        dump("R11");

        // R10: byte counter wraps modulo 2^CNT_W
        for (int k = 0; k < 43; k++) tx_frame(1, 1536, 0, 0);
        do_read(1, 19, v, vld);
        check("R10", "tx bytes after wrap", v, (43 * 1536) & MASK);
        exp_q[1][19] = 0;
        do_read(1, 38, v, vld);
        check("R10", "top bin count", v, 43);
        exp_q[1][38] = 0;
        dump("R10");

        finish_run();
    end

endmodule